// File: doc/BRIEF.md
# Four-Port Host FIFO Access Unit

This block sits between a host bus and four network ports. Each port has a receive queue, which the port side fills and the host drains, and a transmit queue, which the host fills and the port side drains. Every host access is timed by one free-running strobe clock, at most 33 MHz. Two active-low enable pairs pick the operation on each edge. The receive pair gates queue reads and the transmit pair gates queue writes. When both conditions hold on the same edge, a read and a write go ahead together.

A 2-bit port select steers the host's reads and writes. It also steers three single-cycle commands: clearing a port's receive error flag, clearing a port's transmit retry flag, and aborting the packet a port is receiving. Four active-low byte enables qualify every 32-bit word. On writes they are stored with the word so that the port side receives them. On reads, disabled byte lanes come back as zero.

Per-port ready and error flags leave the core together with an output-enable signal for each interface. The pad ring uses that signal to drive the flags or float them. The flags are driven only while the interface enable is asserted.

Top module: `quad_fifo_host`

## Requirements
- R1: A receive read takes place on a strobe edge only when `rx_if_en_n` and `rx_rd_en_n` are both 0. It pops the head word of the selected receive queue, and that word appears on `host_rdata` after the edge. With either enable at 1, no queue changes and `host_rdata` holds its value.
- R2: A transmit write takes place on a strobe edge only when `tx_if_en_n` and `tx_wr_en_n` are both 0. It appends `host_wdata` and `byte_en_n` to the selected transmit queue. The port side sees the queue in first-in first-out order on `mac_tx_rdata` and `mac_tx_rbe_n`, and `mac_tx_pop` removes the head.
- R3: `port_sel` value 0 selects port index 0 (bit 0 of every per-port vector). Values 1, 2 and 3 select port indices 1, 2 and 3.
- R4: On a read, byte lane i of `host_rdata` (bits 8i+7..8i) is zero when `byte_en_n[i]` is 1. Otherwise it is that byte of the popped word.
- R5: `rx_flags_oe` equals the inverse of `rx_if_en_n`, and `tx_flags_oe` equals the inverse of `tx_if_en_n`.
- R6: `rx_ready[p]` is 1 exactly when receive queue p holds at least one word. `tx_ready[p]` is 1 exactly when transmit queue p has room for another word.
- R7: A read from an empty receive queue changes no queue and leaves `host_rdata` unchanged. It sets `rx_status` for that port, and the flag stays set until it is cleared.
- R8: A write to a full transmit queue is discarded. It sets `tx_retry` for that port, and the flag stays set until it is cleared.
- R9: `rx_status_clr` clears `rx_status` of the selected port only, and `tx_retry_clr` clears `tx_retry` of the selected port only. These commands do not depend on the interface enables. When a new error on the same port arrives in the same cycle as its clear, the flag ends up set.
- R10: `rx_abort` empties the selected receive queue in one edge, so its `rx_ready` bit is 0 after that edge. A port-side push to that queue on the same edge is dropped.
- R11: When a read and a write qualify on the same edge, both complete, whichever ports are involved.
- R12: After a synchronous reset, all queues are empty, `rx_status` and `tx_retry` are 0, and `host_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host access strobe, free-running |
| rst | input | 1 | Synchronous reset, active high |
| rx_if_en_n | input | 1 | Receive interface enable, active low |
| rx_rd_en_n | input | 1 | Receive read enable, active low |
| tx_if_en_n | input | 1 | Transmit interface enable, active low |
| tx_wr_en_n | input | 1 | Transmit write enable, active low |
| port_sel | input | 2 | Target port for accesses and commands |
| byte_en_n | input | 4 | Byte lane enables, active low |
| host_wdata | input | 32 | Word written to a transmit queue |
| host_rdata | output | 32 | Word last read from a receive queue |
| rx_status_clr | input | 1 | Clear receive error of the selected port |
| tx_retry_clr | input | 1 | Clear transmit retry of the selected port |
| rx_abort | input | 1 | Flush the selected receive queue |
| rx_ready | output | 4 | Receive queue non-empty, per port |
| rx_status | output | 4 | Sticky receive error, per port |
| rx_flags_oe | output | 1 | Drive enable for the receive flags |
| tx_ready | output | 4 | Transmit queue has room, per port |
| tx_retry | output | 4 | Sticky transmit overflow, per port |
| tx_flags_oe | output | 1 | Drive enable for the transmit flags |
| mac_rx_push | input | 4 | Port-side push into each receive queue |
| mac_rx_wdata | input | 128 | Port-side receive words, 32 bits per port |
| mac_rx_full | output | 4 | Receive queue full, per port |
| mac_tx_pop | input | 4 | Port-side pop from each transmit queue |
| mac_tx_rdata | output | 128 | Transmit queue head words, 32 bits per port |
| mac_tx_rbe_n | output | 16 | Transmit queue head byte enables, 4 per port |
| mac_tx_avail | output | 4 | Transmit queue non-empty, per port |

## Verification
The assertions are checked on every edge. They cover the following cases:
- A gated or empty-queue read leaves `host_rdata` unchanged.
- A read from an empty queue and a write to a full queue each set the error flag of the port that was selected on that edge.
- An abort always leaves that port's ready bit low.
- The error flags never drop except for the port that a clear command selected.

Only the bench scenarios show the following:
- The data path itself: byte masking and first-in first-out ordering.
- Port decoding of the stored words.
- Set-over-clear priority on the same edge.
- A read and a write completing together.

// File: rtl/quad_fifo_pkg.sv
package quad_fifo_pkg;

    localparam int NPORT = 4;
    localparam int DW    = 32;
    localparam int NB    = DW / 8;
    localparam int PSW   = $clog2(NPORT);

    typedef struct packed {
        logic [NB-1:0] be_n;
        logic [DW-1:0] data;
    } tx_word_t;

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [NPORT-1:0] sel;
    } host_cmd_t;

    function automatic logic [NPORT-1:0] port_onehot(input logic [PSW-1:0] ps);
        logic [NPORT-1:0] v;
        v = '0;
        v[ps] = 1'b1;
        return v;
    endfunction

    function automatic logic [DW-1:0] keep_bytes(input logic [DW-1:0] d,
                                                 input logic [NB-1:0] ben);
        logic [DW-1:0] r;
        for (int i = 0; i < NB; i++) begin
            r[8*i +: 8] = ben[i] ? 8'h00 : d[8*i +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/host_access_decode.sv
module host_access_decode
    import quad_fifo_pkg::*;
(
    input  logic           rx_if_en_n,
    input  logic           rx_rd_en_n,
    input  logic           tx_if_en_n,
    input  logic           tx_wr_en_n,
    input  logic [PSW-1:0] port_sel,
    output host_cmd_t      cmd
);
    always_comb begin
        cmd.rd  = !rx_if_en_n && !rx_rd_en_n;
        cmd.wr  = !tx_if_en_n && !tx_wr_en_n;
        cmd.sel = port_onehot(port_sel);
    end
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    // a new event wins over a clear on the same edge
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr) | set;
    end
endmodule

// File: rtl/port_fifo.sv
module port_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/quad_fifo_host.sv
module quad_fifo_host
    import quad_fifo_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_if_en_n,
    input  logic                 rx_rd_en_n,
    input  logic                 tx_if_en_n,
    input  logic                 tx_wr_en_n,
    input  logic [PSW-1:0]       port_sel,
    input  logic [NB-1:0]        byte_en_n,
    input  logic [DW-1:0]        host_wdata,
    output logic [DW-1:0]        host_rdata,
    input  logic                 rx_status_clr,
    input  logic                 tx_retry_clr,
    input  logic                 rx_abort,
    output logic [NPORT-1:0]     rx_ready,
    output logic [NPORT-1:0]     rx_status,
    output logic                 rx_flags_oe,
    output logic [NPORT-1:0]     tx_ready,
    output logic [NPORT-1:0]     tx_retry,
    output logic                 tx_flags_oe,
    input  logic [NPORT-1:0]     mac_rx_push,
    input  logic [NPORT*DW-1:0]  mac_rx_wdata,
    output logic [NPORT-1:0]     mac_rx_full,
    input  logic [NPORT-1:0]     mac_tx_pop,
    output logic [NPORT*DW-1:0]  mac_tx_rdata,
    output logic [NPORT*NB-1:0]  mac_tx_rbe_n,
    output logic [NPORT-1:0]     mac_tx_avail
);
    localparam int TXW = $bits(tx_word_t);

    host_cmd_t        cmd;
    logic [NPORT-1:0] rx_empty, rx_full, tx_empty, tx_full;
    logic [NPORT-1:0] rx_pop, tx_push, rx_flush;
    logic [NPORT-1:0] rx_err_set, rx_err_clr, tx_err_set, tx_err_clr;
    logic [DW-1:0]    rx_head [NPORT];
    tx_word_t         tx_head [NPORT];
    tx_word_t         tx_in;

    host_access_decode u_dec (
        .rx_if_en_n (rx_if_en_n),
        .rx_rd_en_n (rx_rd_en_n),
        .tx_if_en_n (tx_if_en_n),
        .tx_wr_en_n (tx_wr_en_n),
        .port_sel   (port_sel),
        .cmd        (cmd)
    );

    assign rx_pop   = cmd.rd        ? cmd.sel : '0;
    assign tx_push  = cmd.wr        ? cmd.sel : '0;
    assign rx_flush = rx_abort      ? cmd.sel : '0;
    assign rx_err_clr = rx_status_clr ? cmd.sel : '0;
    assign tx_err_clr = tx_retry_clr  ? cmd.sel : '0;
    assign rx_err_set = rx_pop & rx_empty;
    assign tx_err_set = tx_push & tx_full;

    assign tx_in.be_n = byte_en_n;
    assign tx_in.data = host_wdata;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        port_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
            .clk   (clk),
            .rst   (rst),
            .flush (rx_flush[p]),
            .push  (mac_rx_push[p]),
            .wdata (mac_rx_wdata[p*DW +: DW]),
            .pop   (rx_pop[p]),
            .rdata (rx_head[p]),
            .empty (rx_empty[p]),
            .full  (rx_full[p])
        );

        port_fifo #(.W(TXW), .DEPTH(DEPTH)) u_txq (
            .clk   (clk),
            .rst   (rst),
            .flush (1'b0),
            .push  (tx_push[p]),
            .wdata (tx_in),
            .pop   (mac_tx_pop[p]),
            .rdata (tx_head[p]),
            .empty (tx_empty[p]),
            .full  (tx_full[p])
        );

        assign mac_tx_rdata[p*DW +: DW] = tx_head[p].data;
        assign mac_tx_rbe_n[p*NB +: NB] = tx_head[p].be_n;
    end

    sticky_flag #(.N(NPORT)) u_rx_err (
        .clk (clk), .rst (rst), .set (rx_err_set), .clr (rx_err_clr), .q (rx_status)
    );

    sticky_flag #(.N(NPORT)) u_tx_err (
        .clk (clk), .rst (rst), .set (tx_err_set), .clr (tx_err_clr), .q (tx_retry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
        end else if (cmd.rd && !rx_empty[port_sel]) begin
            host_rdata <= keep_bytes(rx_head[port_sel], byte_en_n);
        end
    end

    assign rx_ready     = ~rx_empty;
    assign tx_ready     = ~tx_full;
    assign mac_rx_full  = rx_full;
    assign mac_tx_avail = ~tx_empty;
    assign rx_flags_oe  = !rx_if_en_n;
    assign tx_flags_oe  = !tx_if_en_n;
endmodule

// File: rtl/quad_fifo_host_chk.sv
module quad_fifo_host_chk
    import quad_fifo_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             rx_if_en_n,
    input logic             rx_rd_en_n,
    input logic             tx_if_en_n,
    input logic             tx_wr_en_n,
    input logic [PSW-1:0]   port_sel,
    input logic [DW-1:0]    host_rdata,
    input logic             rx_status_clr,
    input logic             tx_retry_clr,
    input logic             rx_abort,
    input logic [NPORT-1:0] rx_ready,
    input logic [NPORT-1:0] rx_status,
    input logic [NPORT-1:0] tx_ready,
    input logic [NPORT-1:0] tx_retry
);
    logic rd_q, wr_q;
    logic [NPORT-1:0] rx_keep, tx_keep;

    assign rd_q    = !rx_if_en_n && !rx_rd_en_n;
    assign wr_q    = !tx_if_en_n && !tx_wr_en_n;
    assign rx_keep = rx_status_clr ? ~port_onehot(port_sel) : '1;
    assign tx_keep = tx_retry_clr  ? ~port_onehot(port_sel) : '1;

    // R1: gated read leaves the read register alone
    a_r1_gated_read_holds: assert property (@(posedge clk) disable iff (rst)
        !rd_q |=> $stable(host_rdata));

    // R7: empty read keeps data and raises the port's error flag
    a_r7_empty_read_holds: assert property (@(posedge clk) disable iff (rst)
        (rd_q && !rx_ready[port_sel]) |=> $stable(host_rdata));

    a_r7_empty_read_flags: assert property (@(posedge clk) disable iff (rst)
        (rd_q && !rx_ready[port_sel]) |=> rx_status[$past(port_sel)]);

    // R8: write into a full queue raises the retry flag
    a_r8_full_write_flags: assert property (@(posedge clk) disable iff (rst)
        (wr_q && !tx_ready[port_sel]) |=> tx_retry[$past(port_sel)]);

    // R10: abort leaves the port with nothing to read
    a_r10_abort_empties: assert property (@(posedge clk) disable iff (rst)
        rx_abort |=> !rx_ready[$past(port_sel)]);

    // R9: flags only drop on the port a clear command selected
    a_r9_rx_sticky: assert property (@(posedge clk) disable iff (rst)
        rx_ready[0] || !rx_ready[0] |=> (($past(rx_status) & $past(rx_keep) & ~rx_status) == '0));

    a_r9_tx_sticky: assert property (@(posedge clk) disable iff (rst)
        tx_ready[0] || !tx_ready[0] |=> (($past(tx_retry) & $past(tx_keep) & ~tx_retry) == '0));
endmodule

bind quad_fifo_host quad_fifo_host_chk u_chk (.*);

// File: tb/tb_quad_fifo_host.sv
`timescale 1ns/1ps
module tb_quad_fifo_host;
    logic         clk = 1'b0;
    logic         rst;
    logic         rx_if_en_n, rx_rd_en_n, tx_if_en_n, tx_wr_en_n;
    logic [1:0]   port_sel;
    logic [3:0]   byte_en_n;
    logic [31:0]  host_wdata, host_rdata;
    logic         rx_status_clr, tx_retry_clr, rx_abort;
    logic [3:0]   rx_ready, rx_status, tx_ready, tx_retry;
    logic         rx_flags_oe, tx_flags_oe;
    logic [3:0]   mac_rx_push, mac_rx_full, mac_tx_pop, mac_tx_avail;
    logic [127:0] mac_rx_wdata, mac_tx_rdata;
    logic [15:0]  mac_tx_rbe_n;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    quad_fifo_host #(.DEPTH(4)) dut (.*);

    typedef struct packed {
        logic [1:0]  port;
        logic [31:0] word;
        logic [3:0]  ben;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 32'h1122_3344, 4'b0000},
        '{2'd1, 32'hDEAD_BEEF, 4'b0001},
        '{2'd2, 32'hCAFE_F00D, 4'b1010},
        '{2'd3, 32'h0BAD_C0DE, 4'b1111},
        '{2'd3, 32'hFFFF_FFFF, 4'b0110},
        '{2'd2, 32'h8765_4321, 4'b1000},
        '{2'd1, 32'h5A5A_A5A5, 4'b0100},
        '{2'd0, 32'h0F0F_F0F0, 4'b1110}
    };

    function automatic logic [31:0] expect_mask(input logic [31:0] w, input logic [3:0] b);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = b[i] ? 8'h00 : w[8*i +: 8];
        return r;
    endfunction

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle;
        rx_if_en_n = 1; rx_rd_en_n = 1; tx_if_en_n = 1; tx_wr_en_n = 1;
        rx_status_clr = 0; tx_retry_clr = 0; rx_abort = 0;
        mac_rx_push = '0; mac_tx_pop = '0;
    endtask

    task automatic mac_push(input int p, input logic [31:0] w);
        mac_rx_wdata[p*32 +: 32] = w;
        mac_rx_push = 4'b0001 << p;
        tick;
        mac_rx_push = '0;
    endtask

    task automatic host_read(input int p, input logic [3:0] b);
        port_sel = 2'(p); byte_en_n = b;
        rx_if_en_n = 0; rx_rd_en_n = 0;
        tick;
        rx_if_en_n = 1; rx_rd_en_n = 1;
    endtask

    task automatic host_write(input int p, input logic [31:0] w, input logic [3:0] b);
        port_sel = 2'(p); byte_en_n = b; host_wdata = w;
        tx_if_en_n = 0; tx_wr_en_n = 0;
        tick;
        tx_if_en_n = 1; tx_wr_en_n = 1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        idle;
        port_sel = 0; byte_en_n = 0; host_wdata = 0; mac_rx_wdata = '0;
        rst = 1;
        repeat (3) tick;
        rst = 0;
        tick;

        // R12 reset state
        check("R12 rdata", host_rdata, 32'h0);
        check("R12 rx_ready", {28'h0, rx_ready}, 32'h0);
        check("R12 tx_ready", {28'h0, tx_ready}, 32'hF);
        check("R12 flags", {24'h0, rx_status, tx_retry}, 32'h0);

        // R5 drive enables
        check("R5 rx oe off", {31'h0, rx_flags_oe}, 32'h0);
        check("R5 tx oe off", {31'h0, tx_flags_oe}, 32'h0);
        rx_if_en_n = 0; tx_if_en_n = 0; #1;
        check("R5 rx oe on", {31'h0, rx_flags_oe}, 32'h1);
        check("R5 tx oe on", {31'h0, tx_flags_oe}, 32'h1);
        idle; tick;

        // R1 R3 R4 R6 vector walk
        for (int i = 0; i < 8; i++) begin
            mac_push(VECS[i].port, VECS[i].word);
            check("R3 R6 ready one port", {28'h0, rx_ready}, {28'h0, 4'b0001 << VECS[i].port});
            host_read(VECS[i].port, VECS[i].ben);
            check("R1 R4 read data", host_rdata, expect_mask(VECS[i].word, VECS[i].ben));
            check("R6 drained", {28'h0, rx_ready}, 32'h0);
        end

        // R1 gating: either enable high blocks the read
        mac_push(2, 32'h1357_9BDF);
        held = host_rdata;
        port_sel = 2; byte_en_n = 0;
        rx_if_en_n = 1; rx_rd_en_n = 0; tick;
        rx_if_en_n = 0; rx_rd_en_n = 1; tick;
        idle;
        check("R1 gated keep queue", {28'h0, rx_ready}, 32'h4);
        check("R1 gated keep data", host_rdata, held);
        host_read(2, 4'b0000);
        check("R1 read after gate", host_rdata, 32'h1357_9BDF);

        // R7 empty read
        held = host_rdata;
        host_read(1, 4'b0000);
        check("R7 data held", host_rdata, held);
        check("R7 status set", {28'h0, rx_status}, 32'h2);
        tick;
        check("R7 sticky", {28'h0, rx_status}, 32'h2);

        // R9 clear on wrong port, right port, set wins
        port_sel = 0; rx_status_clr = 1; tick; rx_status_clr = 0;
        check("R9 wrong port clear", {28'h0, rx_status}, 32'h2);
        port_sel = 1; rx_status_clr = 1; tick; rx_status_clr = 0;
        check("R9 right port clear", {28'h0, rx_status}, 32'h0);
        port_sel = 3; rx_status_clr = 1; rx_if_en_n = 0; rx_rd_en_n = 0; tick; idle;
        check("R9 set wins", {28'h0, rx_status}, 32'h8);
        port_sel = 3; rx_status_clr = 1; tick; rx_status_clr = 0;
        check("R9 cleared", {28'h0, rx_status}, 32'h0);

        // R2 write path to port side
        host_write(2, 32'hA5A5_0001, 4'b0101);
        check("R2 avail", {28'h0, mac_tx_avail}, 32'h4);
        check("R2 data", mac_tx_rdata[64 +: 32], 32'hA5A5_0001);
        check("R2 be", {28'h0, mac_tx_rbe_n[8 +: 4]}, 32'h5);
        port_sel = 0; tx_if_en_n = 0; tx_wr_en_n = 1; tick;
        tx_if_en_n = 1; tx_wr_en_n = 0; tick; idle;
        check("R2 gated write", {28'h0, mac_tx_avail}, 32'h4);

        // R8 fill port 0
        for (int k = 0; k < 4; k++) host_write(0, 32'h100 + k, 4'(k));
        check("R6 R8 full", {28'h0, tx_ready}, 32'hE);
        host_write(0, 32'hFFFF_0000, 4'b0000);
        check("R8 retry set", {28'h0, tx_retry}, 32'h1);
        check("R8 head kept", mac_tx_rdata[31:0], 32'h100);
        for (int k = 0; k < 4; k++) begin
            check("R2 fifo order", mac_tx_rdata[31:0], 32'h100 + k);
            check("R2 fifo be order", {28'h0, mac_tx_rbe_n[3:0]}, 32'(k));
            mac_tx_pop = 4'b0001; tick; mac_tx_pop = '0;
        end
        check("R8 nothing extra", {28'h0, mac_tx_avail}, 32'h4);
        port_sel = 0; tx_retry_clr = 1; tick; tx_retry_clr = 0;
        check("R9 tx clear", {28'h0, tx_retry}, 32'h0);

        // R10 abort
        mac_push(3, 32'h1); mac_push(3, 32'h2);
        port_sel = 3; rx_abort = 1; tick; rx_abort = 0;
        check("R10 flushed", {28'h0, rx_ready}, 32'h0);
        mac_rx_wdata[96 +: 32] = 32'h3; mac_rx_push = 4'b1000;
        port_sel = 3; rx_abort = 1; tick; idle;
        check("R10 push dropped", {28'h0, rx_ready}, 32'h0);

        // R11 simultaneous read and write
        mac_push(0, 32'hBEEF_0000);
        port_sel = 0; byte_en_n = 0; host_wdata = 32'h7777_8888;
        rx_if_en_n = 0; rx_rd_en_n = 0; tx_if_en_n = 0; tx_wr_en_n = 0;
        tick; idle;
        check("R11 read done", host_rdata, 32'hBEEF_0000);
        check("R11 write done", mac_tx_rdata[31:0], 32'h7777_8888);
        check("R11 avail", {28'h0, mac_tx_avail}, 32'h5);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule